// File: doc/BRIEF.md
# System Error Interrupt Aggregator

This block gathers 64 error-interrupt sources into one registered interrupt line. The sources come in two classes. The low 21 sources are level-sensitive wires. The remaining 43 sources are event sources. An event source is raised when its number is written to a dedicated set register on a small memory-mapped bus. Both classes share one cause space and one mask space. Each space is split into two 32-bit words, and source `n` lives in word `n/32` at bit `n%32`.

Software reads the two cause words to get the full pending bitmap. It acknowledges sources by writing ones to the cause words, and it enables or disables sources through the two mask words. The output line stays high while any pending source is enabled. A level source that is acknowledged while its wire is still high comes back on the following cycle, so it stays pending until the wire drops.

Top module: `err_irq_agg`

## Requirements
- R1: After reset both cause words read 0, both mask words read 0xFFFFFFFF, and `irq_o` is 0.
- R2: The byte offsets are fixed. Cause words are at 0x00 (sources 0–31) and 0x04 (sources 32–63). Mask words are at 0x20 and 0x24. The write-only set register is at 0x30. Source n maps to bit n%32 of word n/32.
- R3: While wire input `n` (n from 0 to 20) is high at a clock edge, cause bit `n` reads 1 from the next cycle onward.
- R4: Writing a 1 to a cause bit clears it, and writing 0 leaves it unchanged. If a wired source's input is still high, its bit reads 1 again one cycle after the clear.
- R5: A write of a value from 21 to 63 to the set register sets exactly that cause bit on the next cycle, and leaves every other bit unchanged.
- R6: Set-register writes whose data is below 21 or above 63 change no cause bit.
- R7: Mask words are written and read as whole words. A mask bit of 1 disables its source for `irq_o`, and a mask bit of 0 enables it. Masking does not clear the cause bit.
- R8: `irq_o` is registered. In each cycle it equals the OR over all sources of (cause AND NOT mask), taken from the previous cycle.
- R9: Reads of the set register and of any undecoded offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wire_irq_i | input | 21 | Level-sensitive error wires for sources 0–20, active high |
| bus_req_i | input | 1 | Bus access strobe, single cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 6 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the addressed word |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The bench goes after several corner cases:
- A level source cleared while its wire is held high. A design that let the clear win permanently would lose the error, and one that let the level win in the clear cycle would never show the one-cycle gap.
- Set writes at the range edges (20, 21, 63, 64 and large values). An off-by-one decoder would set a wired bit or drop source 63.
- Source 32, which sits across the word boundary. A design that mapped it to the wrong word would fail there.
- Masking a pending bit and then unmasking it. This checks that the cause bit survives the mask.
- The output timing, compared on every clock. A design with a combinational output or an extra register stage is reported.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int unsigned SRC_NUM   = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WIRED_NUM = 21;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned CAUSE_OFF = 'h00;
  localparam int unsigned MASK_OFF  = 'h20;
  localparam int unsigned SET_OFF   = 'h30;
endpackage

// File: rtl/err_irq_set_dec.sv
module err_irq_set_dec #(
  parameter int unsigned SRC_NUM   = 64,
  parameter int unsigned WIRED_NUM = 21,
  parameter int unsigned DATA_W    = 32
) (
  input  logic               we_i,
  input  logic [DATA_W-1:0]  num_i,
  output logic [SRC_NUM-1:0] set_o
);
  for (genvar n = 0; n < SRC_NUM; n++) begin : g_bit
    if (n < WIRED_NUM) begin : g_wired
      assign set_o[n] = 1'b0;
    end else begin : g_msg
      assign set_o[n] = we_i && (num_i == DATA_W'(n));
    end
  end

  always_comb begin
    p_set_onehot_r5 : assert ($onehot0(set_o));
    if (!(num_i >= DATA_W'(WIRED_NUM) && num_i < DATA_W'(SRC_NUM)))
      p_set_range_r6 : assert (set_o == '0);
  end
endmodule

// File: rtl/err_irq_bank.sv
module err_irq_bank #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] lvl_i,
  input  logic [WORD_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] cause_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              pend_o
);
  logic [WORD_W-1:0] cause_q, mask_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  // level re-arms one cycle after a clear; set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= ((cause_q | lvl_i) & ~clr) | set_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign pend_o  = |(cause_q & ~mask_q);

  p_level_sets_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((cause_o & $past(lvl_i)) == $past(lvl_i)));
  p_clear_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((cause_o & $past(wdata_i & ~set_i)) == '0));
  p_keep_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
  p_set_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));
  p_mask_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> (mask_o == $past(mask_o)));
endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg #(
  parameter int unsigned SRC_NUM   = err_irq_pkg::SRC_NUM,
  parameter int unsigned WORD_W    = err_irq_pkg::WORD_W,
  parameter int unsigned WIRED_NUM = err_irq_pkg::WIRED_NUM,
  parameter int unsigned ADDR_W    = err_irq_pkg::ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WIRED_NUM-1:0] wire_irq_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [WORD_W-1:0]    bus_wdata_i,
  output logic [WORD_W-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  import err_irq_pkg::*;

  localparam int unsigned WORD_NUM = SRC_NUM / WORD_W;
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFF);

  logic                 wr, set_we;
  logic [SRC_NUM-1:0]   lvl_vec, set_vec;
  logic [WORD_W-1:0]    cause_w [WORD_NUM];
  logic [WORD_W-1:0]    mask_w  [WORD_NUM];
  logic [WORD_NUM-1:0]  pend_w;
  logic                 irq_q;

  assign wr      = bus_req_i && bus_we_i;
  assign set_we  = wr && (bus_addr_i == SET_A);
  assign lvl_vec = {{(SRC_NUM-WIRED_NUM){1'b0}}, wire_irq_i};

  err_irq_set_dec #(
    .SRC_NUM(SRC_NUM), .WIRED_NUM(WIRED_NUM), .DATA_W(WORD_W)
  ) set_dec_i (
    .we_i(set_we), .num_i(bus_wdata_i), .set_o(set_vec)
  );

  for (genvar k = 0; k < WORD_NUM; k++) begin : g_word
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CAUSE_OFF + 4*k);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_OFF + 4*k);
    err_irq_bank #(.WORD_W(WORD_W)) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_vec[k*WORD_W +: WORD_W]),
      .set_i     (set_vec[k*WORD_W +: WORD_W]),
      .clr_we_i  (wr && (bus_addr_i == CA)),
      .mask_we_i (wr && (bus_addr_i == MA)),
      .wdata_i   (bus_wdata_i),
      .cause_o   (cause_w[k]),
      .mask_o    (mask_w[k]),
      .pend_o    (pend_w[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < WORD_NUM; k++) begin
      if (bus_addr_i == ADDR_W'(CAUSE_OFF + 4*k)) bus_rdata_o = cause_w[k];
      if (bus_addr_i == ADDR_W'(MASK_OFF + 4*k))  bus_rdata_o = mask_w[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_w;
  end
  assign irq_o = irq_q;

  p_irq_follows_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|pend_w)));
  p_set_rd_zero_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == SET_A) |-> (bus_rdata_o == '0));
endmodule

// File: tb/err_irq_agg_tb_top.sv
`timescale 1ns/1ps
module err_irq_agg_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [20:0] wire_irq = '0;
  logic        req = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_irq_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wire_irq_i(wire_irq),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit m_cause [64];
  bit m_mask  [64];
  bit m_irq;

  initial begin
    for (int n = 0; n < 64; n++) begin m_cause[n] = 0; m_mask[n] = 1; end
    m_irq = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit any;
      any = 0;
      for (int n = 0; n < 64; n++) if (m_cause[n] && !m_mask[n]) any = 1;
      m_irq = any;
      for (int n = 0; n < 64; n++) begin
        bit clr, lvl, st;
        clr = req && we && addr == ((n < 32) ? 6'h00 : 6'h04) && wdata[n % 32];
        lvl = (n < 21) && wire_irq[n];
        st  = req && we && addr == 6'h30 && n >= 21 && wdata == 32'(n);
        m_cause[n] = ((m_cause[n] || lvl) && !clr) || st;
      end
      if (req && we && addr == 6'h20) for (int b = 0; b < 32; b++) m_mask[b] = wdata[b];
      if (req && we && addr == 6'h24) for (int b = 0; b < 32; b++) m_mask[32+b] = wdata[b];
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < 32; b++) begin
      case (a)
        6'h00: v[b] = m_cause[b];
        6'h04: v[b] = m_cause[32+b];
        6'h20: v[b] = m_mask[b];
        6'h24: v[b] = m_mask[32+b];
        default: v[b] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // R8: output compared every clock
  always @(negedge clk) if (rst_n && !done) chk(irq === m_irq, "R8", 32'(irq), 32'(m_irq));

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, string r);
    @(negedge clk); req = 1; we = 0; addr = a; #1;
    chk(rdata === exp_rd(a), r, rdata, exp_rd(a));
    @(negedge clk); req = 0;
  endtask

  task automatic rd_lit(logic [5:0] a, logic [31:0] e, string r);
    @(negedge clk); req = 1; we = 0; addr = a; #1;
    chk(rdata === e, r, rdata, e);
    @(negedge clk); req = 0;
  endtask

  initial begin
    #100000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    #1 chk(irq === 1'b0, "R1", 32'(irq), 0);
    rst_n = 1;
    rd_lit(6'h00, 32'h0, "R1");
    rd_lit(6'h04, 32'h0, "R1");
    rd_lit(6'h20, 32'hFFFFFFFF, "R1");
    rd_lit(6'h24, 32'hFFFFFFFF, "R1");
    // R3 level sources
    @(negedge clk); wire_irq = 21'h100005;
    @(negedge clk); wire_irq = '0;
    rd_lit(6'h00, 32'h00100005, "R3");
    // R4 clear with W1C, zeros ignored
    wr(6'h00, 32'h00000004);
    rd_lit(6'h00, 32'h00100001, "R4");
    wr(6'h00, 32'h0);
    rd_lit(6'h00, 32'h00100001, "R4");
    // R4 level still high re-arms after one cycle
    @(negedge clk); wire_irq = 21'h2;
    @(negedge clk); req = 1; we = 1; addr = 6'h00; wdata = 32'hFFFFFFFF;
    @(negedge clk); req = 0; we = 0; addr = 6'h00; #1;
    chk(rdata === 32'h0, "R4", rdata, 0);
    @(negedge clk); #1;
    chk(rdata === 32'h2, "R4", rdata, 32'h2);
    wire_irq = '0;
    wr(6'h00, 32'hFFFFFFFF);
    rd_lit(6'h00, 32'h0, "R4");
    // R5 set register, range edges and word boundary (R2)
    wr(6'h30, 32'd21);
    rd_lit(6'h00, 32'h00200000, "R5");
    wr(6'h30, 32'd63);
    wr(6'h30, 32'd32);
    rd_lit(6'h04, 32'h80000001, "R2");
    // R6 out of range ignored
    wr(6'h30, 32'd20);
    wr(6'h30, 32'd64);
    wr(6'h30, 32'h80000015);
    rd_lit(6'h00, 32'h00200000, "R6");
    rd_lit(6'h04, 32'h80000001, "R6");
    // R7 masking
    wr(6'h24, 32'hFFFFFFFE);
    rd_lit(6'h24, 32'hFFFFFFFE, "R7");
    repeat (2) @(negedge clk);
    chk(irq === 1'b1, "R7", 32'(irq), 1);
    wr(6'h24, 32'hFFFFFFFF);
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R7", 32'(irq), 0);
    rd_lit(6'h04, 32'h80000001, "R7");
    // R9 set register and holes read zero
    rd_lit(6'h30, 32'h0, "R9");
    rd_lit(6'h10, 32'h0, "R9");
    rd_lit(6'h3C, 32'h0, "R9");
    // R2/R8 random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      int s;
      s = $urandom_range(0, 5);
      a = (s == 0) ? 6'h00 : (s == 1) ? 6'h04 : (s == 2) ? 6'h20 :
          (s == 3) ? 6'h24 : (s == 4) ? 6'h30 : 6'(4 * $urandom_range(0, 15));
      @(negedge clk);
      wire_irq = ($urandom_range(0, 3) == 0) ? 21'($urandom) : '0;
      if ($urandom_range(0, 1) == 1) begin
        req = 1; we = 1; addr = a;
        wdata = (a == 6'h30) ? 32'($urandom_range(0, 70)) : $urandom;
      end else begin
        req = 1; we = 0; addr = a; #1;
        chk(rdata === exp_rd(a), "R2", rdata, exp_rd(a));
      end
    end
    @(negedge clk); req = 0; we = 0; wire_irq = '0;
    rd(6'h00, "R2");
    rd(6'h04, "R2");
    rd(6'h20, "R7");
    rd(6'h24, "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule